// File: doc/BRIEF.md
# Dual-Direction Mailbox Bypass

The block gives two independently clocked ports a side channel around a one-way data queue. Each direction has a single 36-bit holding register. Mailbox one carries a word from port A to port B, and mailbox two carries a word from port B to port A. A port reaches a mailbox by raising its mailbox-select input during an enabled access. With the select low, the same access becomes a strobe to the queue, which lies outside this block.

Each mailbox has an active-low full flag in the writer's clock domain. The flag drops on the edge that accepts a write. It rises again only after the other port has taken the word, and that event reaches the writer through a toggle-and-synchronize handshake. The reader's domain has a ready flag that rises once the write toggle has crossed over.

Each direction is run by two small state machines. The writer side has states WR_IDLE and WR_HELD: the transition "accept" (a mailbox write while idle) leads to WR_HELD, and the transition "ack" (the synchronized read toggle catches up with the write toggle) leads back to WR_IDLE. The reader side has states RD_EMPTY and RD_READY: the transition "arrive" (the synchronized write toggle differs from the read toggle) leads to RD_READY, and the transition "take" (a mailbox read while ready) leads back to RD_EMPTY. Port B's output bus selects between mailbox-one contents and queue data. Each port reports when its bus should be driven.

Top module: `mailbox_bypass`

## Requirements
- R1: A port A access with a_en=1, a_dir_wr=1, a_mbx_sel=1 while mail1_full_n=1 stores a_din in mailbox one, and mail1_full_n reads 0 after that clk_a edge. Port B writes mailbox two the same way, with b_en=1, b_dir_rd=0, b_mbx_sel=1.
- R2: A mailbox write attempted while that mailbox's full flag is 0 is ignored, and the stored word is unchanged.
- R3: A port B access with b_en=1, b_dir_rd=1, b_mbx_sel=1 while mail1_ready_b=1 drops mail1_ready_b after that clk_b edge. mail1_full_n then returns to 1 within 6 clk_a cycles.
- R4: A port A access with a_en=1, a_dir_wr=0, a_mbx_sel=1 while mail2_ready_a=1 drops mail2_ready_a. mail2_full_n then returns to 1 within 6 clk_b cycles, and a_dout shows the word port B wrote.
- R5: rst_a_n low forces mail1_full_n=1 and mail1_ready_b=0. rst_b_n low does the same for mailbox two. prst_n low does it for both mailboxes.
- R6: b_oe equals b_dir_rd. b_dout shows mailbox-one contents when b_mbx_sel=1 and fifo_rdata when b_mbx_sel=0.
- R7: a_oe equals the inverse of a_dir_wr, and a_dout shows mailbox-two contents.
- R8: fifo_wr_en is 1 only for a_en=1, a_dir_wr=1, a_mbx_sel=0. fifo_rd_en is 1 only for b_en=1, b_dir_rd=1, b_mbx_sel=0. A mailbox access never strobes the queue.
- R9: The reader's ready flag rises within 4 reader cycles after a write. A mailbox read while the ready flag is 0 has no effect: a later write still holds the full flag low until that word is read.
- R10: Words pass through mailbox one in write order, each delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A full reset, active low, clears mailbox one |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B full reset, active low, clears mailbox two |
| prst_n | input | 1 | Partial reset, active low, clears both mailboxes |
| a_en | input | 1 | Port A access enable |
| a_dir_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_mbx_sel | input | 1 | Port A targets a mailbox when 1 |
| a_din | input | 36 | Port A write data |
| a_dout | output | 36 | Port A read data (mailbox two) |
| a_oe | output | 1 | Port A bus drive enable |
| b_en | input | 1 | Port B access enable |
| b_dir_rd | input | 1 | Port B direction, 1 = read, 0 = write |
| b_mbx_sel | input | 1 | Port B targets a mailbox when 1 |
| b_din | input | 36 | Port B write data |
| b_dout | output | 36 | Port B read data (mailbox one or queue) |
| b_oe | output | 1 | Port B bus drive enable |
| fifo_rdata | input | 36 | Queue read data to be muxed onto port B |
| fifo_wr_en | output | 1 | Queue write strobe from port A |
| fifo_rd_en | output | 1 | Queue read strobe from port B |
| mail1_full_n | output | 1 | Mailbox one full flag, clk_a domain, active low |
| mail1_ready_b | output | 1 | Mailbox one holds a word, clk_b domain |
| mail2_full_n | output | 1 | Mailbox two full flag, clk_b domain, active low |
| mail2_ready_a | output | 1 | Mailbox two holds a word, clk_a domain |

## Verification
The writer's "ack" transition and a new mailbox write can land on the same clk_a edge. That write must still be refused, and the next edge must accept it. The bench provokes this by holding a port A mailbox write with a fresh word continuously while port B takes the old one. It then judges that the first word read is the old value, that mail1_full_n is seen high for exactly one clk_a cycle, and that the word read next is the fresh one.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_HELD = 1'b1
    } wr_state_t;

    typedef enum logic {
        RD_EMPTY = 1'b0,
        RD_READY = 1'b1
    } rd_state_t;

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int W           = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic         wr_clk,
    input  logic         wr_rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    output logic         full_n,
    input  logic         rd_clk,
    input  logic         rd_rst_n,
    input  logic         rd_req,
    output logic [W-1:0] rd_data,
    output logic         ready
);

    logic [W-1:0] data_q;
    logic         wr_tog, rd_tog;
    logic         rd_tog_w, wr_tog_r;
    logic         wr_accept, rd_take;
    wr_state_t    wr_state, wr_next;
    rd_state_t    rd_state, rd_next;

    // Read-toggle into the writer domain, write-toggle into the reader domain
    mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_tog), .q(rd_tog_w)
    );
    mbx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_tog), .q(wr_tog_r)
    );

    // ---------------- writer side ----------------
    always_comb begin
        wr_next   = wr_state;
        wr_accept = 1'b0;
        unique case (wr_state)
            WR_IDLE: if (wr_req) begin
                wr_next   = WR_HELD;   // accept
                wr_accept = 1'b1;
            end
            WR_HELD: if (rd_tog_w == wr_tog) begin
                wr_next   = WR_IDLE;   // ack
            end
        endcase
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wr_state <= WR_IDLE;
            wr_tog   <= 1'b0;
            data_q   <= '0;
        end else begin
            wr_state <= wr_next;
            if (wr_accept) begin
                wr_tog <= ~wr_tog;
                data_q <= wr_data;
            end
        end
    end

    always_comb begin
        full_n = (wr_state == WR_IDLE);
    end

    // ---------------- reader side ----------------
    always_comb begin
        rd_next = rd_state;
        rd_take = 1'b0;
        unique case (rd_state)
            RD_EMPTY: if (wr_tog_r != rd_tog) begin
                rd_next = RD_READY;    // arrive
            end
            RD_READY: if (rd_req) begin
                rd_next = RD_EMPTY;    // take
                rd_take = 1'b1;
            end
        endcase
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rd_state <= RD_EMPTY;
            rd_tog   <= 1'b0;
        end else begin
            rd_state <= rd_next;
            if (rd_take) rd_tog <= ~rd_tog;
        end
    end

    always_comb begin
        ready   = (rd_state == RD_READY);
        rd_data = data_q;
    end

    // ---------------- assertions ----------------
    p_set_on_write_r1: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_req && full_n) |=> (!full_n && data_q == $past(wr_data)));

    p_block_when_full_r2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_req && !full_n) |=> (data_q == $past(data_q)));

    p_clear_on_read_r3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_req && ready) |=> !ready);

    p_empty_read_r9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!ready) |=> (rd_tog == $past(rd_tog)));

endmodule

// File: rtl/mailbox_bypass.sv
module mailbox_bypass #(
    parameter int W           = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk_a,
    input  logic         rst_a_n,
    input  logic         clk_b,
    input  logic         rst_b_n,
    input  logic         prst_n,
    input  logic         a_en,
    input  logic         a_dir_wr,
    input  logic         a_mbx_sel,
    input  logic [W-1:0] a_din,
    output logic [W-1:0] a_dout,
    output logic         a_oe,
    input  logic         b_en,
    input  logic         b_dir_rd,
    input  logic         b_mbx_sel,
    input  logic [W-1:0] b_din,
    output logic [W-1:0] b_dout,
    output logic         b_oe,
    input  logic [W-1:0] fifo_rdata,
    output logic         fifo_wr_en,
    output logic         fifo_rd_en,
    output logic         mail1_full_n,
    output logic         mail1_ready_b,
    output logic         mail2_full_n,
    output logic         mail2_ready_a
);

    localparam int RST_STAGES = 2;

    logic         m1_src_n, m2_src_n;
    logic         m1_rst_a, m1_rst_b, m2_rst_a, m2_rst_b;
    logic         m1_wr_req, m1_rd_req, m2_wr_req, m2_rd_req;
    logic [W-1:0] m1_data, m2_data;

    // Reset sources: each mailbox follows its writer's full reset and the partial reset
    assign m1_src_n = rst_a_n & prst_n;
    assign m2_src_n = rst_b_n & prst_n;

    mbx_sync #(.STAGES(RST_STAGES)) u_rs_m1a (.clk(clk_a), .rst_n(m1_src_n), .d(1'b1), .q(m1_rst_a));
    mbx_sync #(.STAGES(RST_STAGES)) u_rs_m1b (.clk(clk_b), .rst_n(m1_src_n), .d(1'b1), .q(m1_rst_b));
    mbx_sync #(.STAGES(RST_STAGES)) u_rs_m2a (.clk(clk_a), .rst_n(m2_src_n), .d(1'b1), .q(m2_rst_a));
    mbx_sync #(.STAGES(RST_STAGES)) u_rs_m2b (.clk(clk_b), .rst_n(m2_src_n), .d(1'b1), .q(m2_rst_b));

    // Access decode
    always_comb begin
        fifo_wr_en = a_en &  a_dir_wr & ~a_mbx_sel;
        m1_wr_req  = a_en &  a_dir_wr &  a_mbx_sel;
        m2_rd_req  = a_en & ~a_dir_wr &  a_mbx_sel;
        fifo_rd_en = b_en &  b_dir_rd & ~b_mbx_sel;
        m1_rd_req  = b_en &  b_dir_rd &  b_mbx_sel;
        m2_wr_req  = b_en & ~b_dir_rd &  b_mbx_sel;
    end

    mbx_channel #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_mail1 (
        .wr_clk(clk_a), .wr_rst_n(m1_rst_a), .wr_req(m1_wr_req), .wr_data(a_din),
        .full_n(mail1_full_n),
        .rd_clk(clk_b), .rd_rst_n(m1_rst_b), .rd_req(m1_rd_req), .rd_data(m1_data),
        .ready(mail1_ready_b)
    );

    mbx_channel #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_mail2 (
        .wr_clk(clk_b), .wr_rst_n(m2_rst_b), .wr_req(m2_wr_req), .wr_data(b_din),
        .full_n(mail2_full_n),
        .rd_clk(clk_a), .rd_rst_n(m2_rst_a), .rd_req(m2_rd_req), .rd_data(m2_data),
        .ready(mail2_ready_a)
    );

    // Bus steering
    always_comb begin
        a_oe   = ~a_dir_wr;
        a_dout = m2_data;
        b_oe   = b_dir_rd;
        b_dout = b_mbx_sel ? m1_data : fifo_rdata;
    end

    p_fifo_wr_gate_r8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (a_en && a_mbx_sel) |-> !fifo_wr_en);

    p_fifo_rd_gate_r8: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (b_en && b_mbx_sel) |-> !fifo_rd_en);

endmodule

// File: tb/mailbox_bypass_test.sv
module mailbox_bypass_test;

    localparam int W = 36;

    logic clk_a = 0, clk_b = 0;
    logic rst_a_n = 0, rst_b_n = 0, prst_n = 0;
    logic a_en = 0, a_dir_wr = 1, a_mbx_sel = 0;
    logic b_en = 0, b_dir_rd = 1, b_mbx_sel = 0;
    logic [W-1:0] a_din = '0, b_din = '0, fifo_rdata = '0;
    logic [W-1:0] a_dout, b_dout;
    logic a_oe, b_oe, fifo_wr_en, fifo_rd_en;
    logic mail1_full_n, mail1_ready_b, mail2_full_n, mail2_ready_a;

    int n_chk = 0, n_fail = 0;
    logic [W-1:0] exp_q[$];

    always #10 clk_a = ~clk_a;   // 50 MHz
    always #13 clk_b = ~clk_b;

    mailbox_bypass uut (.*);

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic a_write1(input logic [W-1:0] d);
        @(negedge clk_a); a_en = 1; a_dir_wr = 1; a_mbx_sel = 1; a_din = d;
        @(negedge clk_a); a_en = 0; a_mbx_sel = 0;
    endtask

    task automatic b_read1(output logic [W-1:0] d);
        @(negedge clk_b); b_en = 1; b_dir_rd = 1; b_mbx_sel = 1;
        #1 d = b_dout;
        @(negedge clk_b); b_en = 0; b_mbx_sel = 0;
    endtask

    task automatic b_write2(input logic [W-1:0] d);
        @(negedge clk_b); b_en = 1; b_dir_rd = 0; b_mbx_sel = 1; b_din = d;
        @(negedge clk_b); b_en = 0; b_dir_rd = 1; b_mbx_sel = 0;
    endtask

    task automatic a_read2(output logic [W-1:0] d);
        @(negedge clk_a); a_en = 1; a_dir_wr = 0; a_mbx_sel = 1;
        #1 d = a_dout;
        @(negedge clk_a); a_en = 0; a_dir_wr = 1; a_mbx_sel = 0;
    endtask

    task automatic wait_ready_b(output int cyc);
        cyc = 0;
        while (!mail1_ready_b && cyc < 50) begin @(negedge clk_b); cyc++; end
    endtask

    task automatic wait_full1_high(output int cyc);
        cyc = 0;
        while (!mail1_full_n && cyc < 50) begin @(negedge clk_a); cyc++; end
    endtask

    task automatic do_reset();
        rst_a_n = 0; rst_b_n = 0; prst_n = 0;
        repeat (3) @(negedge clk_b);
        rst_a_n = 1; rst_b_n = 1; prst_n = 1;
        repeat (4) @(negedge clk_b);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk_a);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] got;
        int cyc;
        int high_cnt;
        do_reset();

        // R5 reset state
        check("R5 mail1_full_n reset", mail1_full_n, 1);
        check("R5 mail2_full_n reset", mail2_full_n, 1);
        check("R5 mail1_ready_b reset", mail1_ready_b, 0);
        check("R5 mail2_ready_a reset", mail2_ready_a, 0);

        // R8 queue strobes
        @(negedge clk_a); a_en = 1; a_dir_wr = 1; a_mbx_sel = 0; #1;
        check("R8 fifo_wr_en queue write", fifo_wr_en, 1);
        a_mbx_sel = 1; a_en = 0; #1;
        check("R8 fifo_wr_en idle", fifo_wr_en, 0);
        b_en = 1; b_dir_rd = 1; b_mbx_sel = 0; #1;
        check("R8 fifo_rd_en queue read", fifo_rd_en, 1);
        b_en = 0; #1;
        check("R8 fifo_rd_en idle", fifo_rd_en, 0);
        a_mbx_sel = 0;

        // R6 / R7 bus steering
        fifo_rdata = 36'h9_1234_5678; b_dir_rd = 1; b_mbx_sel = 0; #1;
        check("R6 b_dout queue data", b_dout, 36'h9_1234_5678);
        check("R6 b_oe read", b_oe, 1);
        b_dir_rd = 0; #1;
        check("R6 b_oe write", b_oe, 0);
        b_dir_rd = 1;
        a_dir_wr = 1; #1;
        check("R7 a_oe write", a_oe, 0);
        a_dir_wr = 0; #1;
        check("R7 a_oe read", a_oe, 1);
        a_dir_wr = 1;

        // R9 empty read has no effect
        b_read1(got);
        repeat (6) @(negedge clk_a);
        check("R9 full flag after empty read", mail1_full_n, 1);

        // R1 write, R2 blocked write
        a_write1(36'h0_0000_00A5);
        check("R1 mail1_full_n low after write", mail1_full_n, 0);
        wait_ready_b(cyc);
        check("R9 ready within 4 cycles", (cyc <= 4), 1);
        a_write1(36'h0_0000_003C);
        repeat (10) @(negedge clk_a);
        check("R9 flag still low after empty read", mail1_full_n, 0);
        b_mbx_sel = 1; #1;
        check("R6 b_dout mailbox data", b_dout, 36'h0_0000_00A5);
        b_mbx_sel = 0;
        b_read1(got);
        check("R2 blocked write left word", got, 36'h0_0000_00A5);
        #1 check("R3 ready drops after take", mail1_ready_b, 0);
        @(negedge clk_a);
        wait_full1_high(cyc);
        check("R3 full flag rises within 6", (cyc <= 6), 1);

        // R4 mailbox two
        b_write2(36'hF_0F0F_0F0F);
        check("R4 mail2_full_n low after write", mail2_full_n, 0);
        cyc = 0;
        while (!mail2_ready_a && cyc < 50) begin @(negedge clk_a); cyc++; end
        a_read2(got);
        check("R4 a_dout mailbox two", got, 36'hF_0F0F_0F0F);
        cyc = 0;
        while (!mail2_full_n && cyc < 50) begin @(negedge clk_b); cyc++; end
        check("R4 mail2 flag rises within 6", (cyc <= 6), 1);

        // Same-edge ack and write: hold a write while B takes the word (R2, R1)
        a_write1(36'h1_1111_1111);
        wait_ready_b(cyc);
        @(negedge clk_a); a_en = 1; a_dir_wr = 1; a_mbx_sel = 1; a_din = 36'h2_2222_2222;
        high_cnt = 0;
        fork
            begin
                repeat (20) begin @(negedge clk_a); if (mail1_full_n) high_cnt++; end
            end
            begin
                b_read1(got);
                check("R2 held write blocked until ack", got, 36'h1_1111_1111);
            end
        join
        a_en = 0; a_mbx_sel = 0;
        check("R1 full flag high exactly one cycle", high_cnt, 1);
        check("R1 re-armed flag low", mail1_full_n, 0);
        wait_ready_b(cyc);
        b_read1(got);
        check("R1 word accepted after ack", got, 36'h2_2222_2222);
        @(negedge clk_a);
        wait_full1_high(cyc);

        // R10 scoreboard
        fork
            begin : driver
                for (int i = 0; i < 6; i++) begin
                    logic [W-1:0] d;
                    wait_full1_high(cyc);
                    d = 36'hC_0000_0000 + 36'(i * 7 + 1);
                    exp_q.push_back(d);
                    a_write1(d);
                end
            end
            begin : monitor
                for (int i = 0; i < 6; i++) begin
                    logic [W-1:0] r, e;
                    wait_ready_b(cyc);
                    b_read1(r);
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : '1;
                    check("R10 in-order delivery", r, e);
                end
            end
        join
        check("R10 queue drained", 36'(exp_q.size()), 0);

        // R5 partial reset clears both mailboxes
        @(negedge clk_a); wait_full1_high(cyc);
        a_write1(36'h5);
        b_write2(36'h6);
        repeat (6) @(negedge clk_b);
        prst_n = 0; #1;
        check("R5 partial reset mail1 flag", mail1_full_n, 1);
        check("R5 partial reset mail2 flag", mail2_full_n, 1);
        check("R5 partial reset mail1 ready", mail1_ready_b, 0);
        repeat (2) @(negedge clk_b); prst_n = 1;
        repeat (4) @(negedge clk_b);

        // R5 port A full reset clears mailbox one only
        a_write1(36'h7);
        b_write2(36'h8);
        repeat (6) @(negedge clk_b);
        rst_a_n = 0; #1;
        check("R5 full reset A mail1 flag", mail1_full_n, 1);
        check("R5 full reset A keeps mail2", mail2_full_n, 0);
        repeat (2) @(negedge clk_b); rst_a_n = 1;
        repeat (4) @(negedge clk_b);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule